// File: doc/BRIEF.md
# Serial CRC Frame-Check Generator

This block computes a cyclic redundancy check over a message that arrives one bit per clock, most significant bit first, and then sends the resulting frame check sequence out serially. It is a feedback shift register whose XOR taps come from a generator-polynomial parameter. The message bit is combined with the bit leaving the top stage, so the division runs as though n zero bits followed the message, although those zeros are never clocked in. Once the last message bit has been accepted, the register holds the remainder. The block then shifts that remainder out with the feedback forced to zero, and it flags completion with a single-cycle pulse.

A user pulses `start` while the block is idle. The user then presents message bits with `din_valid`, marks the final bit with `din_last`, and takes the n check bits from `fcs_bit` while `fcs_valid` is high. These bits follow directly after the message, in the cycles right after the last bit. The polynomial parameter `POLY` holds the coefficients of x^(n-1) down to x^0. The x^n coefficient is implied, and bit 0 must be 1.

Top module: `serial_fcs_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `done` and `fcs_valid` are all low.
- R2: A `start` seen while idle clears every register stage to zero and raises `busy` on the next cycle.
- R3: Each accepted message bit forms feedback = bit XOR top stage. The register then shifts up by one and, when the feedback is 1, XORs in `POLY`. After the last bit the register equals M(x)·x^n mod G(x). With the default n=5 and G = x^5+x^2+x+1, the message 10000000 gives 11010 (x^4 coefficient first).
- R4: With n=4 and G = x^4+x^3+1 (`POLY` = 4'b1001), the message 11100110 gives the check sequence 0110.
- R5: During the message phase, a cycle with `din_valid` low leaves the register unchanged, so idle gaps do not change the result.
- R6: In the n cycles right after the cycle that accepts the bit with `din_last` high, `fcs_valid` is high and `fcs_bit` carries the remainder, x^(n-1) coefficient first. The register shifts with zero feedback.
- R7: `done` is high for exactly one cycle, the cycle after the n-th check bit. In that cycle `busy` and `fcs_valid` are low.
- R8: `start` while busy (message or output phase) is ignored, and the frame's result is unchanged.
- R9: `din_valid` while idle has no effect: `busy` and `fcs_valid` stay low.
- R10: `start` may be given in the cycle in which `done` is high, and it begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new frame (accepted only when idle) |
| din_valid | input | 1 | Qualifies `din` during the message phase |
| din | input | 1 | Message bit, MSB first |
| din_last | input | 1 | Marks the final message bit (with `din_valid`) |
| busy | output | 1 | Frame in progress (message or check output) |
| done | output | 1 | One-cycle pulse after the last check bit |
| fcs_valid | output | 1 | `fcs_bit` carries a check bit |
| fcs_bit | output | 1 | Serial check sequence, high-order bit first |

## Verification
A lone 1 followed by zeros reaches the remainder only through repeated feedback, so it exposes wrong tap positions. The two worked divisions pin down the exact polynomial mapping for n=5 and n=4. An all-zero message separates a correct clear from stale register contents. A long mixed pattern and a single-bit message test the tap XORs across many feedback events and at the shortest frame length. Frames with idle gaps, frames with stray `start` pulses, and a back-to-back start on the `done` cycle show whether hold, ignore and restart behave as required.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MSG   = 2'd1,
        PH_DRAIN = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_STEP  = 2'd2,
        OP_DRAIN = 2'd3
    } lfsr_op_t;

    typedef struct packed {
        lfsr_op_t op;
        logic     bit_in;
    } lfsr_cmd_t;

endpackage

// File: rtl/fcs_divider.sv
module fcs_divider
    import fcs_pkg::*;
#(
    parameter int              WIDTH = 5,
    parameter logic [WIDTH-1:0] TAPS = 5'b00111
) (
    input  logic             clk,
    input  logic             rst,
    input  lfsr_cmd_t        cmd,
    output logic [WIDTH-1:0] rem
);
    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] step_v;
    logic             fb;

    // feedback: incoming message bit against the stage leaving the top
    assign fb = cmd.bit_in ^ rem_q[WIDTH-1];

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            if (i == 0) begin : g_low
                assign step_v[0] = fb & TAPS[0];
            end else begin : g_mid
                assign step_v[i] = rem_q[i-1] ^ (fb & TAPS[i]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else begin
            unique case (cmd.op)
                OP_CLEAR: rem_q <= '0;
                OP_STEP:  rem_q <= step_v;
                OP_DRAIN: rem_q <= {rem_q[WIDTH-2:0], 1'b0};
                default:  rem_q <= rem_q;
            endcase
        end
    end

    assign rem = rem_q;
endmodule

// File: rtl/fcs_sequencer.sv
module fcs_sequencer
    import fcs_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      din_valid,
    input  logic      din,
    input  logic      din_last,
    output lfsr_cmd_t cmd,
    output logic      busy,
    output logic      done,
    output logic      fcs_valid,
    output logic      msg_phase
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WIDTH - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) phase_q <= PH_MSG;
                end
                PH_MSG: begin
                    if (din_valid && din_last) begin
                        phase_q <= PH_DRAIN;
                        cnt_q   <= '0;
                    end
                end
                PH_DRAIN: begin
                    if (cnt_q == CNT_END) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd.bit_in = din;
        cmd.op     = OP_HOLD;
        unique case (phase_q)
            PH_IDLE:  if (start)     cmd.op = OP_CLEAR;
            PH_MSG:   if (din_valid) cmd.op = OP_STEP;
            PH_DRAIN: cmd.op = OP_DRAIN;
            default:  cmd.op = OP_HOLD;
        endcase
    end

    assign busy      = (phase_q != PH_IDLE);
    assign fcs_valid = (phase_q == PH_DRAIN);
    assign msg_phase = (phase_q == PH_MSG);
    assign done      = done_q;
endmodule

// File: rtl/serial_fcs_gen.sv
module serial_fcs_gen
    import fcs_pkg::*;
#(
    parameter int               FCS_W = 5,
    parameter logic [FCS_W-1:0] POLY  = 5'b00111
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic din_valid,
    input  logic din,
    input  logic din_last,
    output logic busy,
    output logic done,
    output logic fcs_valid,
    output logic fcs_bit
);
    lfsr_cmd_t        cmd;
    logic [FCS_W-1:0] rem;
    logic             msg_phase;

    fcs_sequencer #(.WIDTH(FCS_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .din_valid (din_valid),
        .din       (din),
        .din_last  (din_last),
        .cmd       (cmd),
        .busy      (busy),
        .done      (done),
        .fcs_valid (fcs_valid),
        .msg_phase (msg_phase)
    );

    fcs_divider #(.WIDTH(FCS_W), .TAPS(POLY)) u_div (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .rem (rem)
    );

    assign fcs_bit = rem[FCS_W-1];
endmodule

// File: rtl/serial_fcs_gen_checker.sv
module serial_fcs_gen_checker #(
    parameter int FCS_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             din_valid,
    input logic             busy,
    input logic             done,
    input logic             fcs_valid,
    input logic             msg_phase,
    input logic [FCS_W-1:0] rem
);
    localparam int RUN_W = $clog2(FCS_W + 2);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)            run_q <= '0;
        else if (fcs_valid) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy && !done && !fcs_valid));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && rem == '0));

    a_r5_gap_holds: assert property (@(posedge clk) disable iff (rst)
        (msg_phase && !din_valid) |=> $stable(rem));

    a_r6_zero_feedback: assert property (@(posedge clk) disable iff (rst)
        fcs_valid |=> (rem == ($past(rem) << 1)));

    a_r6_run_length: assert property (@(posedge clk) disable iff (rst)
        fcs_valid |-> (run_q < RUN_W'(FCS_W)));

    a_r7_done_after_drain: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !fcs_valid && $past(fcs_valid)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (msg_phase && start) |=> busy);
endmodule

bind serial_fcs_gen serial_fcs_gen_checker #(.FCS_W(FCS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .din_valid (din_valid),
    .busy      (busy),
    .done      (done),
    .fcs_valid (fcs_valid),
    .msg_phase (msg_phase),
    .rem       (rem)
);

// File: tb/serial_fcs_gen_test.sv
`timescale 1ns/1ps
module serial_fcs_gen_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, din_valid = 1'b0, din = 1'b0, din_last = 1'b0;
    logic busy5, done5, fv5, fb5;
    logic busy4, done4, fv4, fb4;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_fcs_gen #(.FCS_W(5), .POLY(5'b00111)) uut (
        .clk(clk), .rst(rst), .start(start), .din_valid(din_valid), .din(din),
        .din_last(din_last), .busy(busy5), .done(done5), .fcs_valid(fv5), .fcs_bit(fb5));

    serial_fcs_gen #(.FCS_W(4), .POLY(4'b1001)) uut4 (
        .clk(clk), .rst(rst), .start(start), .din_valid(din_valid), .din(din),
        .din_last(din_last), .busy(busy4), .done(done4), .fcs_valid(fv4), .fcs_bit(fb4));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // long division of msg*x^n by x^n + poly
    function automatic logic [7:0] golden(input int n, input logic [7:0] poly,
                                          input logic [31:0] msg, input int len);
        logic [7:0] r = '0;
        logic [7:0] mask = 8'((1 << n) - 1);
        for (int i = len - 1; i >= 0; i--) begin
            logic f = msg[i] ^ r[n-1];
            r = (r << 1) & mask;
            if (f) r = r ^ poly;
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // drives one frame through both instances, checks timing and returns results
    task automatic run_frame(input logic [31:0] msg, input int len, input int gap,
                             input bit poke, input bit restart,
                             output logic [4:0] got5, output logic [3:0] got4);
        got5 = '0;
        got4 = '0;
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R2 busy after start", {busy5, busy4}, 2'b11);
        for (int i = len - 1; i >= 0; i--) begin
            for (int g = 0; g < gap; g++) begin
                din_valid = 1'b0; din = ~msg[i]; din_last = 1'b1;
                tick();
            end
            din_valid = 1'b1; din = msg[i]; din_last = (i == 0);
            start = poke && (i == len / 2);
            tick();
            din_valid = 1'b0; din_last = 1'b0; start = 1'b0;
        end
        for (int c = 0; c < 5; c++) begin
            chk("R6 fcs_valid n=5", fv5, 1'b1);
            got5 = {got5[3:0], fb5};
            if (c < 4) begin
                chk("R6 fcs_valid n=4", fv4, 1'b1);
                got4 = {got4[2:0], fb4};
            end else begin
                chk("R7 done n=4", {done4, fv4, busy4}, 3'b100);
            end
            start = poke && (c == 2);
            tick();
            start = 1'b0;
        end
        chk("R7 done pulse n=5", {done5, busy5, fv5}, 3'b100);
        start = restart;
        tick();
        start = 1'b0;
        if (restart) chk("R10 start on done cycle", {busy5, busy4}, 2'b11);
        else chk("R7 done one cycle", {done5, done4, busy5}, 3'b000);
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", {busy5, done5, fv5, busy4, done4, fv4}, 6'b0);
        rst = 1'b0;
        tick();
        chk("R1 after reset", {busy5, done5, fv5, busy4, done4, fv4}, 6'b0);
    endtask

    task automatic t_idle_valid();
        for (int k = 0; k < 3; k++) begin
            din_valid = 1'b1; din = 1'b1; din_last = 1'b1;
            tick();
            chk("R9 idle valid ignored", {busy5, fv5, busy4, fv4}, 4'b0);
        end
        din_valid = 1'b0; din_last = 1'b0;
    endtask

    task automatic t_frame(input string tag, input logic [31:0] msg, input int len,
                           input int gap, input bit poke, input bit restart);
        logic [4:0] g5;
        logic [3:0] g4;
        run_frame(msg, len, gap, poke, restart, g5, g4);
        chk({tag, " n=5"}, g5, 5'(golden(5, 8'h07, msg, len)));
        chk({tag, " n=4"}, g4, 4'(golden(4, 8'h09, msg, len)));
    endtask

    task automatic t_worked();
        logic [4:0] g5;
        logic [3:0] g4;
        run_frame(32'h80, 8, 0, 1'b0, 1'b0, g5, g4);
        chk("R3 10000000 remainder", g5, 5'b11010);
        run_frame(32'hE6, 8, 0, 1'b0, 1'b0, g5, g4);
        chk("R4 11100110 fcs", g4, 4'b0110);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        t_idle_valid();
        t_worked();
        t_frame("R3 long mixed", 32'hDEADBEEF, 32, 0, 1'b0, 1'b0);
        t_frame("R2 all zero after nonzero", 32'h0, 12, 0, 1'b0, 1'b0);
        t_frame("R3 single bit", 32'h1, 1, 0, 1'b0, 1'b0);
        t_frame("R5 gaps", 32'h0001A5C3, 17, 2, 1'b0, 1'b0);
        t_frame("R8 stray start", 32'h00C3F1, 24, 0, 1'b1, 1'b0);
        t_frame("R10 first of pair", 32'h5B, 7, 0, 1'b0, 1'b1);
        t_frame("R10 second of pair", 32'h3A7, 10, 1, 1'b0, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule